// File: doc/BRIEF.md
# Tag Rule Cache

This block sits beside the instruction dispatch stage of a processor where every word carries a word-wide metadata tag. For each dispatched instruction it forms a lookup key from the opcode, the current program-counter tag and the tag of each operand slot. It then searches a small fully associative store of rule instances. On a hit it returns two tags: the one the program counter should carry next and the one to attach to the instruction's result. The pipeline merges these with the ordinary result of the instruction. On a miss it raises a fault, and the instruction must not commit.

A trusted software handler decides whether a faulting tag combination is allowed. If it is, the handler writes the full key and both result tags through the install port, and the instruction is restarted from the same program counter. The block treats every tag as an opaque word. Only installed rules decide outcomes. By convention, opcodes fill the operand slots they do not use with a reserved tag value. The cache compares that value like any other. A flush input empties the whole store in one cycle.

Top module: `tag_rule_cache`

## Requirements
- R1: After reset `rsp_valid` is low and no entry is valid, so the first lookup of any key reports a miss.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high, and low otherwise.
- R3: A lookup hits only when the opcode, the PC tag and every operand tag all equal a valid entry's key. Operand slot i occupies bits [i*TAG_W +: TAG_W] of the operand vector. On a hit, `rsp_pc_tag` and `rsp_res_tag` return that entry's stored tags. A difference in any single field gives a miss.
- R4: A response without a hit has `rsp_fault` high and `rsp_hit` low. `rsp_hit` and `rsp_fault` are never high together. Both output tags are zero in any cycle without a hit.
- R5: An installed rule is visible to lookups issued in the cycle after the install or later. A lookup in the same cycle as the install sees the previous contents.
- R6: Installing a key that is already stored overwrites that entry's tags and does not create a second copy. At most one entry matches any key.
- R7: An install of a new key takes the lowest-numbered free entry. When every entry is valid, it replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset or flush and advances by one, wrapping, after each replacement.
- R8: `flush` invalidates every entry and resets the pointer in one cycle. A lookup in the same cycle reports a miss. An install in the same cycle is discarded.
- R9: Tags are opaque. Keys made entirely of zero tags, the reserved unused-slot value, or of all-ones tags are stored and matched like any other key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request for the dispatched instruction |
| lk_op | input | OP_W | Opcode of the dispatched instruction |
| lk_pc_tag | input | TAG_W | Current program-counter tag |
| lk_arg_tags | input | N_OPND*TAG_W | Operand tags, slot i at bits [i*TAG_W +: TAG_W] |
| flush | input | 1 | Invalidate all rules |
| ins_en | input | 1 | Install a rule this cycle |
| ins_op | input | OP_W | Opcode of the rule key |
| ins_pc_tag | input | TAG_W | PC tag of the rule key |
| ins_arg_tags | input | N_OPND*TAG_W | Operand tags of the rule key |
| ins_new_pc_tag | input | TAG_W | PC tag to return on a hit |
| ins_res_tag | input | TAG_W | Result tag to return on a hit |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_hit | output | 1 | A rule matched |
| rsp_fault | output | 1 | No rule matched; the instruction must not commit |
| rsp_pc_tag | output | TAG_W | Next program-counter tag on a hit, else zero |
| rsp_res_tag | output | TAG_W | Result tag on a hit, else zero |

## Verification
Several properties are checked on every cycle: the one-cycle response timing, the exclusivity of hit and fault, zero tags without a hit, at most one matching entry, and that a flush both empties the store and forces a miss. Each cycle also checks that fills land only on free entries and replacements happen only when the store is full. Other behaviours can only be shown by scenarios with a reference model: returning the correct tags, sensitivity to each key field, same-cycle install ordering, overwrite of an existing key, and the exact replacement order after the store fills.

// File: rtl/tagrc_pkg.sv
package tagrc_pkg;

   // Kind of write the victim selector chose for an install
   typedef enum logic [1:0] {
      WR_NONE   = 2'd0,
      WR_UPDATE = 2'd1,
      WR_FILL   = 2'd2,
      WR_EVICT  = 2'd3
   } wr_kind_e;

   // Width of an entry index, never below one bit
   function automatic int unsigned idx_width(input int unsigned depth);
      return (depth > 2) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/rc_match.sv
module rc_match #(
   parameter int unsigned KEY_W = 102,
   parameter int unsigned DEPTH = 8
) (
   input  logic [DEPTH*KEY_W-1:0] key_tab,
   input  logic [DEPTH-1:0]       valid,
   input  logic [KEY_W-1:0]       probe,
   output logic [DEPTH-1:0]       hit_vec
);

   // One comparator per entry, all in parallel
   for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign hit_vec[e] = valid[e] && (key_tab[e*KEY_W +: KEY_W] == probe);
   end

endmodule

// File: rtl/rc_store.sv
module rc_store #(
   parameter int unsigned KEY_W = 102,
   parameter int unsigned TAG_W = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = tagrc_pkg::idx_width(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [KEY_W-1:0]       wr_key,
   input  logic [TAG_W-1:0]       wr_pc,
   input  logic [TAG_W-1:0]       wr_res,
   output logic [DEPTH*KEY_W-1:0] key_tab,
   output logic [DEPTH*TAG_W-1:0] pc_tab,
   output logic [DEPTH*TAG_W-1:0] res_tab,
   output logic [DEPTH-1:0]       valid
);

   logic [DEPTH-1:0] valid_q;
   logic [KEY_W-1:0] key_q [DEPTH];
   logic [TAG_W-1:0] pc_q  [DEPTH];
   logic [TAG_W-1:0] res_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   // Payload storage carries no reset; valid bits qualify it
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(e))) begin
            key_q[e] <= wr_key;
            pc_q[e]  <= wr_pc;
            res_q[e] <= wr_res;
         end
      end
      assign key_tab[e*KEY_W +: KEY_W] = key_q[e];
      assign pc_tab[e*TAG_W +: TAG_W]  = pc_q[e];
      assign res_tab[e*TAG_W +: TAG_W] = res_q[e];
   end

   assign valid = valid_q;

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid == '0));

   // R5
   write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid[$past(wr_idx)]);

endmodule

// File: rtl/rc_victim.sv
module rc_victim #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = tagrc_pkg::idx_width(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 ins_en,
   input  logic [DEPTH-1:0]     valid,
   input  logic [DEPTH-1:0]     ins_hits,
   output logic [IDX_W-1:0]     wr_idx,
   output tagrc_pkg::wr_kind_e  wr_kind
);
   import tagrc_pkg::*;

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] hit_idx;
   logic             free_found;

   // Lowest free entry and index of an existing match
   always_comb begin
      free_idx   = '0;
      free_found = 1'b0;
      hit_idx    = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (!free_found && !valid[e]) begin
            free_idx   = IDX_W'(e);
            free_found = 1'b1;
         end
         if (ins_hits[e]) begin
            hit_idx = IDX_W'(e);
         end
      end
   end

   always_comb begin
      if (!ins_en) begin
         wr_kind = WR_NONE;
         wr_idx  = '0;
      end else if (|ins_hits) begin
         wr_kind = WR_UPDATE;
         wr_idx  = hit_idx;
      end else if (free_found) begin
         wr_kind = WR_FILL;
         wr_idx  = free_idx;
      end else begin
         wr_kind = WR_EVICT;
         wr_idx  = rr_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (flush) begin
         rr_q <= '0;
      end else if (wr_kind == WR_EVICT) begin
         rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   // R7
   fill_only_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WR_FILL) |-> !valid[wr_idx]);

   // R7
   evict_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WR_EVICT) |-> (&valid));

endmodule

// File: rtl/tag_rule_cache.sv
module tag_rule_cache #(
   parameter int unsigned OP_W   = 6,
   parameter int unsigned TAG_W  = 32,
   parameter int unsigned N_OPND = 2,
   parameter int unsigned DEPTH  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_req,
   input  logic [OP_W-1:0]         lk_op,
   input  logic [TAG_W-1:0]        lk_pc_tag,
   input  logic [N_OPND*TAG_W-1:0] lk_arg_tags,
   input  logic                    flush,
   input  logic                    ins_en,
   input  logic [OP_W-1:0]         ins_op,
   input  logic [TAG_W-1:0]        ins_pc_tag,
   input  logic [N_OPND*TAG_W-1:0] ins_arg_tags,
   input  logic [TAG_W-1:0]        ins_new_pc_tag,
   input  logic [TAG_W-1:0]        ins_res_tag,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   output logic                    rsp_fault,
   output logic [TAG_W-1:0]        rsp_pc_tag,
   output logic [TAG_W-1:0]        rsp_res_tag
);
   import tagrc_pkg::*;

   localparam int unsigned KEY_W = OP_W + TAG_W * (N_OPND + 1);
   localparam int unsigned IDX_W = idx_width(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tag_rule_cache: DEPTH must be at least 2");
   end
   if (N_OPND < 1) begin : g_bad_opnd
      $error("tag_rule_cache: N_OPND must be at least 1");
   end
   if (OP_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("tag_rule_cache: OP_W and TAG_W must be positive");
   end

   logic [KEY_W-1:0]       lk_key;
   logic [KEY_W-1:0]       ins_key;
   logic [DEPTH*KEY_W-1:0] key_tab;
   logic [DEPTH*TAG_W-1:0] pc_tab;
   logic [DEPTH*TAG_W-1:0] res_tab;
   logic [DEPTH-1:0]       valid;
   logic [DEPTH-1:0]       lk_hits;
   logic [DEPTH-1:0]       ins_hits;
   logic [IDX_W-1:0]       wr_idx;
   wr_kind_e               wr_kind;
   logic                   wr_en;
   logic                   hit_now;
   logic [TAG_W-1:0]       rd_pc;
   logic [TAG_W-1:0]       rd_res;

   assign lk_key  = {lk_op, lk_pc_tag, lk_arg_tags};
   assign ins_key = {ins_op, ins_pc_tag, ins_arg_tags};

   rc_match #(.KEY_W(KEY_W), .DEPTH(DEPTH)) lk_match_i (
      .key_tab (key_tab),
      .valid   (valid),
      .probe   (lk_key),
      .hit_vec (lk_hits)
   );

   rc_match #(.KEY_W(KEY_W), .DEPTH(DEPTH)) ins_match_i (
      .key_tab (key_tab),
      .valid   (valid),
      .probe   (ins_key),
      .hit_vec (ins_hits)
   );

   rc_victim #(.DEPTH(DEPTH)) victim_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .ins_en   (ins_en),
      .valid    (valid),
      .ins_hits (ins_hits),
      .wr_idx   (wr_idx),
      .wr_kind  (wr_kind)
   );

   assign wr_en = (wr_kind != WR_NONE) && !flush;

   rc_store #(.KEY_W(KEY_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_key  (ins_key),
      .wr_pc   (ins_new_pc_tag),
      .wr_res  (ins_res_tag),
      .key_tab (key_tab),
      .pc_tab  (pc_tab),
      .res_tab (res_tab),
      .valid   (valid)
   );

   // AND-OR read mux; zero when nothing matches
   always_comb begin
      rd_pc  = '0;
      rd_res = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (lk_hits[e]) begin
            rd_pc  = rd_pc  | pc_tab[e*TAG_W +: TAG_W];
            rd_res = rd_res | res_tab[e*TAG_W +: TAG_W];
         end
      end
   end

   assign hit_now = lk_req && !flush && (|lk_hits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_pc_tag  <= '0;
         rsp_res_tag <= '0;
      end else begin
         rsp_valid   <= lk_req;
         rsp_hit     <= hit_now;
         rsp_fault   <= lk_req && !hit_now;
         rsp_pc_tag  <= hit_now ? rd_pc  : '0;
         rsp_res_tag <= hit_now ? rd_res : '0;
      end
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_valid);

   // R2
   no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_valid);

   // R4
   hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_valid && !rsp_fault));

   // R4
   miss_tags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_pc_tag == '0 && rsp_res_tag == '0));

   // R6
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hits));

   // R8
   flush_forces_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && flush) |=> rsp_fault);

endmodule

// File: tb/tag_rule_cache_tb.sv
module tag_rule_cache_tb_top;

   localparam int OP_W   = 6;
   localparam int TAG_W  = 32;
   localparam int N_OPND = 2;
   localparam int DEPTH  = 8;
   localparam int AR_W   = N_OPND * TAG_W;
   localparam int POOL   = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             lk_req, flush, ins_en;
   logic [OP_W-1:0]  lk_op, ins_op;
   logic [TAG_W-1:0] lk_pc_tag, ins_pc_tag, ins_new_pc_tag, ins_res_tag;
   logic [AR_W-1:0]  lk_arg_tags, ins_arg_tags;
   logic             rsp_valid, rsp_hit, rsp_fault;
   logic [TAG_W-1:0] rsp_pc_tag, rsp_res_tag;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;   // 250 MHz

   tag_rule_cache #(.OP_W(OP_W), .TAG_W(TAG_W), .N_OPND(N_OPND), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_op(lk_op), .lk_pc_tag(lk_pc_tag),
      .lk_arg_tags(lk_arg_tags), .flush(flush), .ins_en(ins_en), .ins_op(ins_op),
      .ins_pc_tag(ins_pc_tag), .ins_arg_tags(ins_arg_tags), .ins_new_pc_tag(ins_new_pc_tag),
      .ins_res_tag(ins_res_tag), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_fault(rsp_fault), .rsp_pc_tag(rsp_pc_tag), .rsp_res_tag(rsp_res_tag)
   );

   // Key pool
   logic [OP_W-1:0]  p_op [POOL];
   logic [TAG_W-1:0] p_pc [POOL];
   logic [AR_W-1:0]  p_ar [POOL];

   // Reference model
   bit               m_v   [DEPTH];
   logic [OP_W-1:0]  m_op  [DEPTH];
   logic [TAG_W-1:0] m_kpc [DEPTH];
   logic [AR_W-1:0]  m_ar  [DEPTH];
   logic [TAG_W-1:0] m_pc  [DEPTH];
   logic [TAG_W-1:0] m_res [DEPTH];
   int               m_ptr;

   function automatic int m_find(int k);
      for (int e = 0; e < DEPTH; e++)
         if (m_v[e] && m_op[e] == p_op[k] && m_kpc[e] == p_pc[k] && m_ar[e] == p_ar[k])
            return e;
      return -1;
   endfunction

   function automatic void m_flush();
      for (int e = 0; e < DEPTH; e++) m_v[e] = 0;
      m_ptr = 0;
   endfunction

   function automatic void m_install(int k, logic [TAG_W-1:0] npc, logic [TAG_W-1:0] nres);
      int idx;
      idx = m_find(k);
      if (idx < 0)
         for (int e = 0; e < DEPTH; e++)
            if (idx < 0 && !m_v[e]) idx = e;
      if (idx < 0) begin
         idx = m_ptr;
         m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
      end
      m_v[idx] = 1; m_op[idx] = p_op[k]; m_kpc[idx] = p_pc[k]; m_ar[idx] = p_ar[k];
      m_pc[idx] = npc; m_res[idx] = nres;
   endfunction

   // One cycle: drive at negedge, update model at posedge, check at next negedge
   task automatic step(bit req, int lk, bit ins, int ik, logic [TAG_W-1:0] ipc,
                       logic [TAG_W-1:0] ires, bit fl, string rq);
      int mi;
      bit ehit;
      logic [TAG_W-1:0] epc, eres;
      lk_req = req; lk_op = p_op[lk]; lk_pc_tag = p_pc[lk]; lk_arg_tags = p_ar[lk];
      ins_en = ins; ins_op = p_op[ik]; ins_pc_tag = p_pc[ik]; ins_arg_tags = p_ar[ik];
      ins_new_pc_tag = ipc; ins_res_tag = ires; flush = fl;
      ehit = 0; epc = '0; eres = '0;
      if (req && !fl) begin
         mi = m_find(lk);
         if (mi >= 0) begin ehit = 1; epc = m_pc[mi]; eres = m_res[mi]; end
      end
      @(posedge clk);
      if (fl) m_flush();
      else if (ins) m_install(ik, ipc, ires);
      @(negedge clk);
      lk_req = 0; ins_en = 0; flush = 0;
      checks++;
      if (rsp_valid !== req || rsp_hit !== (req && ehit) || rsp_fault !== (req && !ehit) ||
          rsp_pc_tag !== epc || rsp_res_tag !== eres) begin
         errors++;
         $display("FAIL %s: got v=%b h=%b f=%b pc=%h res=%h, expected v=%b h=%b f=%b pc=%h res=%h",
                  rq, rsp_valid, rsp_hit, rsp_fault, rsp_pc_tag, rsp_res_tag,
                  req, req && ehit, req && !ehit, epc, eres);
      end
   endtask

   task automatic look(int k, string rq);
      step(1, k, 0, 0, '0, '0, 0, rq);
   endtask

   task automatic put(int k, logic [TAG_W-1:0] npc, logic [TAG_W-1:0] nres, string rq);
      step(0, 0, 1, k, npc, nres, 0, rq);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7301));
      for (int i = 0; i < POOL; i++) begin
         p_op[i] = OP_W'($urandom); p_pc[i] = $urandom; p_ar[i] = {$urandom, $urandom};
      end
      p_op[1] = p_op[0] ^ 6'd1; p_pc[1] = p_pc[0]; p_ar[1] = p_ar[0];           // opcode differs
      p_op[2] = p_op[0]; p_pc[2] = p_pc[0] ^ 32'h8000_0000; p_ar[2] = p_ar[0];   // PC tag differs
      p_op[3] = p_op[0]; p_pc[3] = p_pc[0]; p_ar[3] = p_ar[0] ^ (64'd1 << 32);   // slot 1 differs
      p_op[4] = p_op[0]; p_pc[4] = p_pc[0]; p_ar[4] = p_ar[0] ^ 64'd1;           // slot 0 differs
      p_op[5] = '0; p_pc[5] = '0; p_ar[5] = '0;                                   // unused-slot value
      p_op[6] = '1; p_pc[6] = '1; p_ar[6] = '1;                                   // all ones
      m_flush();
      rst_n = 0; lk_req = 0; ins_en = 0; flush = 0;
      lk_op = '0; lk_pc_tag = '0; lk_arg_tags = '0; ins_op = '0; ins_pc_tag = '0;
      ins_arg_tags = '0; ins_new_pc_tag = '0; ins_res_tag = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         errors++;
         $display("FAIL R1: got v=%b h=%b, expected v=0 h=0", rsp_valid, rsp_hit);
      end
      rst_n = 1;
      look(0, "R1");
      step(0, 0, 0, 0, '0, '0, 0, "R2");
      put(0, 32'hA0A0_0001, 32'hB0B0_0001, "R2");
      look(0, "R3");
      look(1, "R3"); look(2, "R3"); look(3, "R3"); look(4, "R3");
      step(1, 1, 1, 1, 32'h1111_1111, 32'h2222_2222, 0, "R5");
      look(1, "R5");
      put(0, 32'hC0C0_0002, 32'hD0D0_0002, "R6");
      look(0, "R6");
      for (int k = 5; k <= 10; k++) put(k, 32'h100 + k, 32'h200 + k, "R7");
      look(5, "R9"); look(6, "R9");
      put(11, 32'h311, 32'h411, "R7");
      look(0, "R7"); look(1, "R7");
      put(12, 32'h312, 32'h412, "R7");
      look(1, "R7"); look(11, "R7"); look(12, "R7");
      step(1, 5, 1, 2, 32'h5, 32'h6, 1, "R8");
      look(2, "R8"); look(6, "R8");
      put(7, 32'h77, 32'h88, "R8");
      look(7, "R8");
      for (int n = 0; n < 800; n++) begin
         int r;
         r = int'($urandom % 100);
         step(r < 70, int'($urandom % POOL), (r % 3) == 0, int'($urandom % POOL),
              $urandom, $urandom, r == 99, "R3");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule